// File: doc/BRIEF.md
# Issue Queue with Two-Stage Tag Wakeup

This block is an instruction issue queue whose wakeup logic saves comparator work. Instructions arrive with two source tags, each either already ready or still waiting for a producer, and one destination tag. Every cycle up to `BCAST` producers broadcast the destination tags of results that have just been computed. Waiting sources compare those tags against their own. The queue picks the oldest instruction whose two sources are ready and issues one per cycle.

Entries are kept in age order, with the oldest at slot 0. Slots below `N_SINGLE` compare the whole tag at once, so their sources wake at the edge that closes the broadcast cycle. All younger slots first compare only the low `LOW_W` bits. On a low match they latch the broadcast's high bits and finish the compare one cycle later, so they wake one cycle later. Sources whose low bits differ never spend a high-bit compare. Because slots shift down as older instructions leave, an entry moves into the full-compare region as it ages. A combinational output reports how many tag bits were compared in the current cycle, which shows how much comparator work the split saves.

Top module: `twostep_wakeup_iq`

## Requirements
- R1: After reset, and in the cycle after a flush, the queue is empty: `iss_valid`=0 and `disp_ready`=1. In a flush cycle `iss_valid` and `cmp_bits` are 0, any dispatch is dropped, and every entry and every pending high-bit compare is discarded.
- R2: A waiting source in slot i < `N_SINGLE` compares all `TAG_W` bits with each valid broadcast of cycle t. On a match the source is ready at the next edge, so an instruction with no other wait issues in cycle t+1.
- R3: A waiting source in slot i >= `N_SINGLE` compares bits [`LOW_W`-1:0] of each valid broadcast in cycle t. On a match it compares bits [`TAG_W`-1:`LOW_W`] in cycle t+1 and becomes ready only if these also match, so the earliest issue is cycle t+2.
- R4: A low-bit match followed by a high-bit mismatch leaves the source waiting.
- R5: A low-bit mismatch starts no high-bit compare in the next cycle.
- R6: `cmp_bits` equals `LOW_W` per low-stage compare, plus `TAG_W`-`LOW_W` per high-stage compare, plus `TAG_W` per full compare. A compare is one waiting source against one valid broadcast port, or one pending high-bit compare. The value is 0 with no valid broadcast and nothing pending.
- R7: A source flagged ready at dispatch is never compared. A broadcast port whose valid bit is 0 never matches and is not counted. An entry is not compared against the broadcasts of the cycle in which it is dispatched.
- R8: `iss_valid` flags the oldest entry with both sources ready and `iss_dst` carries its destination tag. It leaves the queue at that edge, and younger entries move down one slot.
- R9: `disp_ready` is 1 exactly when slot `DEPTH`-1 is empty. A dispatch with `disp_ready`=0 is ignored, so the queue holds at most `DEPTH` entries.
- R10: A high-bit compare that is pending when its entry moves into a slot below `N_SINGLE` still completes and wakes the source.
- R11: The full-compare region follows age: after older entries issue, an entry that was in a two-stage slot wakes through a full compare in the cycle of the broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all entries and pending compares |
| disp_valid | input | 1 | Dispatch request |
| disp_dst | input | TAG_W | Destination tag of the dispatched instruction |
| disp_tag_a | input | TAG_W | First source tag |
| disp_rdy_a | input | 1 | First source already ready |
| disp_tag_b | input | TAG_W | Second source tag |
| disp_rdy_b | input | 1 | Second source already ready |
| disp_ready | output | 1 | A free slot exists |
| bc_valid | input | BCAST | Per-port broadcast valid |
| bc_tags | input | BCAST*TAG_W | Port b tag in bits [b*TAG_W +: TAG_W] |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_dst | output | TAG_W | Destination tag of the issuing instruction |
| cmp_bits | output | CNT_W | Tag bits compared this cycle |

## Verification
The assertions take for granted that `flush`, `disp_valid` and `bc_valid` carry known values from the first clock after reset. They also assume that a broadcast is a plain per-cycle pulse, with no notion of replay or cancel. The design itself drops dispatch attempts into a full queue, so the inputs need no protocol there. The bench drives every input with a defined value in every cycle, including during reset. It draws tags from a narrow pool, so that low-bit matches with high-bit mismatches come up often. It also issues occasional flushes and deliberately pushes dispatches into a full queue.

// File: rtl/twostep_wakeup_iq.sv
module twostep_wakeup_iq #(
  parameter int TAG_W    = 7,
  parameter int LOW_W    = 3,
  parameter int DEPTH    = 16,
  parameter int N_SINGLE = 2,
  parameter int BCAST    = 2,
  parameter int CNT_W    = $clog2(DEPTH*2*BCAST*TAG_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   disp_valid,
  input  logic [TAG_W-1:0]       disp_dst,
  input  logic [TAG_W-1:0]       disp_tag_a,
  input  logic                   disp_rdy_a,
  input  logic [TAG_W-1:0]       disp_tag_b,
  input  logic                   disp_rdy_b,
  output logic                   disp_ready,
  input  logic [BCAST-1:0]       bc_valid,
  input  logic [BCAST*TAG_W-1:0] bc_tags,
  output logic                   iss_valid,
  output logic [TAG_W-1:0]       iss_dst,
  output logic [CNT_W-1:0]       cmp_bits
);
  localparam int HI_W  = TAG_W - LOW_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_W);
  localparam logic [CNT_W-1:0] HI_C   = CNT_W'(HI_W);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(TAG_W);

  logic [DEPTH-1:0] v_q, n_v;
  logic [TAG_W-1:0] dst_q [DEPTH];
  logic [TAG_W-1:0] n_dst [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH][2];
  logic [TAG_W-1:0] n_tag [DEPTH][2];
  logic [1:0]       rdy_q [DEPTH];
  logic [1:0]       w_rdy [DEPTH];
  logic [1:0]       n_rdy [DEPTH];
  logic [BCAST-1:0] pnd_q [DEPTH][2];
  logic [BCAST-1:0] w_pnd [DEPTH][2];
  logic [BCAST-1:0] n_pnd [DEPTH][2];
  logic [HI_W-1:0]  phi_q [DEPTH][2][BCAST];
  logic [HI_W-1:0]  w_phi [DEPTH][2][BCAST];
  logic [HI_W-1:0]  n_phi [DEPTH][2][BCAST];
  logic [TAG_W-1:0] bt [BCAST];
  logic [CNT_W-1:0] acc;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_hit;
  logic [IDX_W:0]   cnt, dpos;
  logic             accept;
  logic             pend_any;

  for (genvar b = 0; b < BCAST; b++) begin : g_bt
    assign bt[b] = bc_tags[b*TAG_W +: TAG_W];
  end

  // wakeup: full compare in the oldest slots, split compare elsewhere
  always_comb begin
    acc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int s = 0; s < 2; s++) begin
        w_rdy[i][s] = rdy_q[i][s];
        w_pnd[i][s] = '0;
        for (int b = 0; b < BCAST; b++) w_phi[i][s][b] = phi_q[i][s][b];
        if (v_q[i] && !rdy_q[i][s]) begin
          for (int b = 0; b < BCAST; b++) begin
            if (pnd_q[i][s][b]) begin
              acc = acc + HI_C;
              if (phi_q[i][s][b] == tag_q[i][s][TAG_W-1:LOW_W]) w_rdy[i][s] = 1'b1;
            end
          end
          for (int b = 0; b < BCAST; b++) begin
            if (bc_valid[b]) begin
              if (i < N_SINGLE) begin
                acc = acc + FULL_C;
                if (bt[b] == tag_q[i][s]) w_rdy[i][s] = 1'b1;
              end else begin
                acc = acc + LOW_C;
                if (bt[b][LOW_W-1:0] == tag_q[i][s][LOW_W-1:0]) begin
                  w_pnd[i][s][b] = 1'b1;
                  w_phi[i][s][b] = bt[b][TAG_W-1:LOW_W];
                end
              end
            end
          end
          if (w_rdy[i][s]) w_pnd[i][s] = '0;
        end
      end
    end
  end

  // oldest-first select
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (v_q[i] && (&rdy_q[i])) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign iss_valid  = sel_hit && !flush;
  assign iss_dst    = dst_q[sel_idx];
  assign cmp_bits   = flush ? '0 : acc;
  assign disp_ready = !v_q[DEPTH-1];
  assign cnt        = ($bits(cnt))'($countones(v_q));
  assign dpos       = cnt - {{IDX_W{1'b0}}, iss_valid};
  assign accept     = disp_valid && disp_ready && !flush;

  // collapse and dispatch
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (iss_valid && (i >= int'(sel_idx))) begin
        n_v[i]   = (i < DEPTH-1) ? v_q[(i+1) % DEPTH] : 1'b0;
        n_dst[i] = dst_q[(i+1) % DEPTH];
        n_rdy[i] = w_rdy[(i+1) % DEPTH];
        for (int s = 0; s < 2; s++) begin
          n_tag[i][s] = tag_q[(i+1) % DEPTH][s];
          n_pnd[i][s] = (i < DEPTH-1) ? w_pnd[(i+1) % DEPTH][s] : '0;
          for (int b = 0; b < BCAST; b++) n_phi[i][s][b] = w_phi[(i+1) % DEPTH][s][b];
        end
      end else begin
        n_v[i]   = v_q[i];
        n_dst[i] = dst_q[i];
        n_rdy[i] = w_rdy[i];
        for (int s = 0; s < 2; s++) begin
          n_tag[i][s] = tag_q[i][s];
          n_pnd[i][s] = w_pnd[i][s];
          for (int b = 0; b < BCAST; b++) n_phi[i][s][b] = w_phi[i][s][b];
        end
      end
      if (accept && (i == int'(dpos))) begin
        n_v[i]      = 1'b1;
        n_dst[i]    = disp_dst;
        n_tag[i][0] = disp_tag_a;
        n_tag[i][1] = disp_tag_b;
        n_rdy[i]    = {disp_rdy_b, disp_rdy_a};
        n_pnd[i][0] = '0;
        n_pnd[i][1] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pnd_q[i][0] <= '0;
        pnd_q[i][1] <= '0;
      end
    end else begin
      v_q <= flush ? '0 : n_v;
      for (int i = 0; i < DEPTH; i++) begin
        pnd_q[i][0] <= flush ? '0 : n_pnd[i][0];
        pnd_q[i][1] <= flush ? '0 : n_pnd[i][1];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      dst_q[i] <= n_dst[i];
      rdy_q[i] <= n_rdy[i];
      for (int s = 0; s < 2; s++) begin
        tag_q[i][s] <= n_tag[i][s];
        for (int b = 0; b < BCAST; b++) phi_q[i][s][b] <= n_phi[i][s][b];
      end
    end
  end

  always_comb begin
    pend_any = 1'b0;
    for (int i = 0; i < DEPTH; i++) pend_any = pend_any | (|pnd_q[i][0]) | (|pnd_q[i][1]);
  end

  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (v_q == '0) && !pend_any);

  a_r4_pend_from_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |-> ($past(bc_valid) != '0) && !$past(flush));

  a_r6_idle_no_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid == '0 && !pend_any) |-> (cmp_bits == '0));

  a_r8_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(cnt) == int'($past(cnt)) + int'($past(accept)) - int'($past(iss_valid)));

  for (genvar gi = N_SINGLE; gi < DEPTH; gi++) begin : g_a3
    for (genvar gs = 0; gs < 2; gs++) begin : g_src
      a_r3_hi_stage_gates: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(v_q[gi]) && !$past(iss_valid) && !$past(flush) &&
         !$past(rdy_q[gi][gs]) && rdy_q[gi][gs]) |-> ($past(pnd_q[gi][gs]) != '0));
    end
  end
endmodule

// File: tb/twostep_wakeup_iq_tb.sv
module twostep_wakeup_iq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, dv = 1'b0, ra = 1'b0, rb = 1'b0;
  logic [6:0] dd = '0, ta = '0, tbv = '0;
  logic [1:0] bv = '0;
  logic [13:0] bct = '0;
  logic disp_ready, iss_valid;
  logic [6:0] iss_dst;
  logic [8:0] cmp_bits;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  twostep_wakeup_iq dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(dv), .disp_dst(dd), .disp_tag_a(ta), .disp_rdy_a(ra),
    .disp_tag_b(tbv), .disp_rdy_b(rb), .disp_ready(disp_ready),
    .bc_valid(bv), .bc_tags(bct),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .cmp_bits(cmp_bits)
  );

  typedef struct packed {
    bit                  v;
    bit [6:0]            dst;
    bit [1:0][6:0]       tag;
    bit [1:0]            r;
    bit [1:0][1:0]       p;
    bit [1:0][1:0][3:0]  h;
  } ent_t;

  ent_t mq [16];
  ent_t nq [16];
  bit   e_iv, e_dr;
  int   e_dst, e_bits;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model_eval();
    ent_t w [16];
    int bits, sel, k;
    bit [6:0] tg;
    bits = 0; sel = -1;
    for (int i = 0; i < 16; i++) begin
      w[i] = mq[i];
      w[i].p = '0;
      for (int s = 0; s < 2; s++) begin
        if (mq[i].v && !mq[i].r[s]) begin
          for (int b = 0; b < 2; b++)
            if (mq[i].p[s][b]) begin
              bits += 4;
              if (mq[i].h[s][b] == mq[i].tag[s][6:3]) w[i].r[s] = 1'b1;
            end
          for (int b = 0; b < 2; b++)
            if (bv[b]) begin
              tg = bct[b*7 +: 7];
              if (i < 2) begin
                bits += 7;
                if (tg == mq[i].tag[s]) w[i].r[s] = 1'b1;
              end else begin
                bits += 3;
                if (tg[2:0] == mq[i].tag[s][2:0]) begin
                  w[i].p[s][b] = 1'b1;
                  w[i].h[s][b] = tg[6:3];
                end
              end
            end
          if (w[i].r[s]) w[i].p[s] = '0;
        end
      end
    end
    for (int i = 0; i < 16; i++)
      if (sel < 0 && mq[i].v && (&mq[i].r)) sel = i;
    e_iv   = (sel >= 0) && !flush;
    e_dst  = (sel >= 0) ? int'(mq[sel].dst) : 0;
    e_bits = flush ? 0 : bits;
    e_dr   = !mq[15].v;
    k = 0;
    for (int i = 0; i < 16; i++) nq[i] = '0;
    for (int i = 0; i < 16; i++)
      if (w[i].v && !(e_iv && i == sel)) begin nq[k] = w[i]; k++; end
    if (dv && e_dr && !flush) begin
      nq[k].v = 1'b1; nq[k].dst = dd;
      nq[k].tag[0] = ta; nq[k].tag[1] = tbv;
      nq[k].r = {rb, ra};
    end
    if (flush) for (int i = 0; i < 16; i++) nq[i] = '0;
  endtask

  task automatic drive(input bit f, input bit v, input bit [6:0] d, input bit [6:0] a,
                       input bit rra, input bit [6:0] bb, input bit rrb,
                       input bit [1:0] bvv, input bit [6:0] t0, input bit [6:0] t1);
    @(negedge clk);
    flush = f; dv = v; dd = d; ta = a; ra = rra; tbv = bb; rb = rrb;
    bv = bvv; bct = {t1, t0};
    #1;
    model_eval();
    chk("R8 model iss_valid", iss_valid, e_iv);
    if (e_iv) chk("R8 model iss_dst", iss_dst, e_dst);
    chk("R6 model cmp_bits", cmp_bits, e_bits);
    chk("R9 model disp_ready", disp_ready, e_dr);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    for (int i = 0; i < 16; i++) mq[i] = nq[i];
  endtask

  task automatic disp(input bit [6:0] d, input bit [6:0] a, input bit rra, input bit [6:0] bb, input bit rrb);
    drive(0, 1, d, a, rra, bb, rrb, 2'b00, 0, 0); tick();
  endtask

  task automatic bcast(input bit [1:0] bvv, input bit [6:0] t0, input bit [6:0] t1);
    drive(0, 0, 0, 0, 0, 0, 0, bvv, t0, t1);
  endtask

  task automatic do_flush();
    drive(1, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0); tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin mq[i] = '0; nq[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset iss_valid", iss_valid, 0);
    chk("R1 reset disp_ready", disp_ready, 1);
    chk("R1 reset cmp_bits", cmp_bits, 0);

    // split compare, counts, region by age
    disp(7'h40, 7'h05, 0, 0, 1);
    disp(7'h41, 7'h06, 0, 0, 1);
    disp(7'h42, 7'h0D, 0, 0, 1);
    disp(7'h43, 7'h15, 0, 0, 1);
    disp(7'h44, 7'h0E, 0, 0, 1);
    bcast(2'b01, 7'h0D, 0);
    chk("R6 mixed compare bits", cmp_bits, 23); tick();
    bcast(2'b00, 0, 0);
    chk("R3 no issue after low stage", iss_valid, 0);
    chk("R5 only low matches go high", cmp_bits, 8); tick();
    bcast(2'b00, 0, 0);
    chk("R3 two-stage wake issue", iss_valid, 1);
    chk("R3 two-stage wake dst", iss_dst, 7'h42);
    chk("R4 high mismatch no pending", cmp_bits, 0); tick();
    bcast(2'b00, 0, 0);
    chk("R4 high mismatch stays waiting", iss_valid, 0); tick();
    bcast(2'b01, 7'h05, 0);
    chk("R6 full plus low bits", cmp_bits, 20); tick();
    bcast(2'b00, 0, 0);
    chk("R2 single-stage next cycle", iss_valid, 1);
    chk("R2 single-stage dst", iss_dst, 7'h40);
    chk("R6 pending high bits", cmp_bits, 4); tick();
    bcast(2'b01, 7'h15, 0);
    chk("R11 promoted entry full compare", cmp_bits, 17); tick();
    bcast(2'b00, 0, 0);
    chk("R11 promoted entry issues", iss_valid, 1);
    chk("R11 promoted entry dst", iss_dst, 7'h43); tick();
    drive(1, 1, 7'h11, 0, 1, 0, 1, 2'b01, 7'h06, 0);
    chk("R1 flush blocks issue", iss_valid, 0);
    chk("R1 flush zero bits", cmp_bits, 0); tick();
    bcast(2'b00, 0, 0);
    chk("R1 empty after flush", disp_ready, 1);
    chk("R1 no issue after flush", iss_valid, 0); tick();

    // pending compare survives a move into the full region
    disp(7'h50, 7'h60, 0, 0, 1);
    disp(7'h51, 7'h61, 0, 0, 1);
    disp(7'h52, 7'h2A, 0, 0, 1);
    bcast(2'b11, 7'h60, 7'h2A);
    chk("R6 two ports bits", cmp_bits, 34); tick();
    bcast(2'b00, 0, 0);
    chk("R8 oldest issues", iss_dst, 7'h50);
    chk("R10 pending high bits", cmp_bits, 4); tick();
    bcast(2'b00, 0, 0);
    chk("R10 moved entry woke", iss_valid, 1);
    chk("R10 moved entry dst", iss_dst, 7'h52); tick();
    do_flush();

    // oldest first among several ready
    disp(7'h60, 7'h30, 0, 0, 1);
    disp(7'h61, 7'h30, 0, 0, 1);
    bcast(2'b10, 0, 7'h30);
    chk("R6 two full compares", cmp_bits, 14); tick();
    bcast(2'b00, 0, 0);
    chk("R8 first oldest", iss_dst, 7'h60); tick();
    bcast(2'b00, 0, 0);
    chk("R8 then next", iss_dst, 7'h61); tick();
    do_flush();

    // ready-at-dispatch, invalid port, dispatch-cycle broadcast
    disp(7'h70, 7'h11, 1, 7'h22, 0);
    drive(0, 1, 7'h71, 7'h33, 0, 0, 1, 2'b01, 7'h11, 7'h22);
    chk("R7 ready source and invalid port skipped", cmp_bits, 7); tick();
    bcast(2'b00, 0, 0);
    chk("R7 no wake from invalid port or dispatch cycle", iss_valid, 0); tick();
    do_flush();

    // full queue
    for (int i = 0; i < 16; i++) disp(7'(i), 7'h7F, 0, 0, 1);
    bcast(2'b00, 0, 0);
    chk("R9 full queue", disp_ready, 0); tick();
    disp(7'h3F, 0, 1, 0, 1);
    bcast(2'b00, 0, 0);
    chk("R9 dispatch into full ignored", iss_valid, 0); tick();
    do_flush();

    // constrained random against the model
    for (int c = 0; c < 4000; c++) begin
      bit [6:0] t0, t1, a, bb;
      bit f;
      t0 = 7'({$urandom_range(3), 1'b0, 2'($urandom_range(3))});
      t1 = 7'({$urandom_range(3), 1'b0, 2'($urandom_range(3))});
      a  = 7'({$urandom_range(3), 1'b0, 2'($urandom_range(3))});
      bb = 7'({$urandom_range(3), 1'b0, 2'($urandom_range(3))});
      f  = ($urandom_range(127) == 0);
      drive(f, $urandom_range(2) != 0, 7'($urandom), a, $urandom_range(1) == 1, bb,
            $urandom_range(1) == 1, 2'({$urandom_range(9) < 4, $urandom_range(9) < 4}), t0, t1);
      tick();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule